// File: doc/BRIEF.md
# Ordered Retrieval Sequencer for a Ternary-Match Store

This controller drives an associative store in which every word is compared at once against a pattern that holds, for each bit position, a 0, a 1 or a don't-care. The store answers each comparison with a match indicator that tells whether no word, exactly one word, or several words matched. The controller keeps one three-valued digit per bit position. It steps those digits like a counter, using only the indicator responses, so that the stored words are pulled out in ascending numeric order. It never returns to the top of the value space after a word has been taken.

A search begins with a one-cycle start pulse. Every interrogation is marked by a probe cycle. In that cycle the pattern outputs are valid and the match indicator is sampled. When a pattern singles out one word, or singles out a set of identical words at full depth, a retrieve strobe follows in the next cycle while the pattern is held. The store uses that strobe to read out the words that match. A done flag rises when the counter runs out past its most significant digit. The flag stays high until the next start pulse.

The controller is a state machine with six states. IDLE waits for start. ASK is the probe cycle. TAKE is the retrieve cycle. DIVE moves to the next lower digit. STEP advances the current digit and carries. FIN shows that the search is done. The transitions are:
- IDLE or FIN goes to ASK on start.
- ASK goes to STEP on no match.
- ASK goes to TAKE on one match, or on a plural match at the least significant digit.
- ASK goes to DIVE on a plural match above the least significant digit.
- TAKE goes to STEP.
- DIVE goes to ASK.
- STEP goes to ASK, or to FIN when the carry leaves the top digit.

Top module: `ordret_ctrl`

## Requirements
- R1: After reset, probe_o, retrieve_o and done_o are 0 and pat_care_o is all zero.
- R2: A start pulse in IDLE or FIN produces a probe on the following cycle. In that probe only the most significant position is specified (pat_care_o bit NSTAGE-1 = 1, all others 0) and its value is 0. pat_care_o=1 marks a specified position, whose required bit is in pat_val_o.
- R3: match_i is sampled in the probe cycle with this encoding: 2'b00 means no word matched, 2'b01 means one word matched, and either 2'b10 or 2'b11 means several words matched.
- R4: On a no-match response, the current digit advances from 0 to 1 and the next probe carries that change. A digit that is already 1 goes to don't-care and carries instead (see R7).
- R5: On a one-match response, retrieve_o is high in the cycle after the probe, with the pattern unchanged. The current digit then advances as in R4.
- R6: On a plural match above the least significant digit, the current digit stays as it is. The next lower digit goes from don't-care to 0, becomes current, and is probed next.
- R7: When a digit goes from 1 to don't-care, the next more significant digit advances and becomes current. Example: 000001 followed by a no-match or retrieval becomes 00001 followed by a don't-care.
- R8: A plural match at the least significant digit means the words are duplicates. They are all retrieved with one retrieve strobe, with every position specified, and the digit then advances.
- R9: When the carry leaves the most significant digit, done_o goes high and pat_care_o is all zero. done_o stays high until the next start.
- R10: The words come out in ascending order, each exactly once. The number of probes equals 2 plus twice the number of prefixes (shorter than NSTAGE bits, at least one bit long) that are shared by two or more stored words.
- R11: A start pulse while a search is running has no effect on that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a search from IDLE or FIN |
| match_i | input | 2 | Match indicator from the store (none / one / plural) |
| probe_o | output | 1 | High in the cycle that interrogates the store |
| pat_val_o | output | NSTAGE | Required bit value per position |
| pat_care_o | output | NSTAGE | 1 where the position is specified, 0 for don't-care |
| retrieve_o | output | 1 | Read out all words that match the current pattern |
| done_o | output | 1 | Search finished; held until the next start |

## Verification
The bench builds the controller with NSTAGE = 6 and models a store of up to sixteen 6-bit words. With that size, the bench can reach every carry chain from the least to the most significant digit. It also covers an empty store, fully duplicated words at the bottom digit, and both plural encodings. Many random fills, including dense fills drawn from small value ranges, exercise deep descents. For each fill, the bench compares the retrieval order against a sorted copy and the probe count against a prefix count.

// File: rtl/ordret_pkg.sv
package ordret_pkg;

    // Digit encoding: bit 1 = position specified, bit 0 = required value.
    typedef enum logic [1:0] {
        DG_FREE = 2'b00,
        DG_ZERO = 2'b10,
        DG_ONE  = 2'b11
    } digit_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK,
        ST_TAKE,
        ST_DIVE,
        ST_STEP,
        ST_FIN
    } state_t;

    typedef enum logic [1:0] {
        RSP_NONE,
        RSP_ONE,
        RSP_MANY
    } resp_t;

    function automatic resp_t decode_resp(input logic [1:0] m);
        if (m[1])      return RSP_MANY;
        else if (m[0]) return RSP_ONE;
        else           return RSP_NONE;
    endfunction

endpackage

// File: rtl/ordret_carry.sv
// Advances the current digit. Digits at 1 from the current position upward
// clear to don't-care until the first 0 digit, which becomes 1 and current.
module ordret_carry
    import ordret_pkg::*;
#(
    parameter int NSTAGE = 6,
    parameter int CW     = 3
) (
    input  digit_t [NSTAGE-1:0] digits_i,
    input  logic   [CW-1:0]     cur_i,
    output digit_t [NSTAGE-1:0] digits_o,
    output logic   [CW-1:0]     cur_o,
    output logic                exhausted_o
);

    logic found;

    always_comb begin
        digits_o = digits_i;
        cur_o    = cur_i;
        found    = 1'b0;
        for (int i = 0; i < NSTAGE; i++) begin
            if (!found && (i >= int'(cur_i))) begin
                if (digits_i[i] == DG_ZERO) begin
                    digits_o[i] = DG_ONE;
                    cur_o       = CW'(i);
                    found       = 1'b1;
                end else begin
                    digits_o[i] = DG_FREE;
                end
            end
        end
        exhausted_o = !found;
    end

endmodule

// File: rtl/ordret_descend.sv
// Opens the next lower digit at 0 and makes it current.
module ordret_descend
    import ordret_pkg::*;
#(
    parameter int NSTAGE = 6,
    parameter int CW     = 3
) (
    input  digit_t [NSTAGE-1:0] digits_i,
    input  logic   [CW-1:0]     cur_i,
    output digit_t [NSTAGE-1:0] digits_o,
    output logic   [CW-1:0]     cur_o
);

    always_comb begin
        digits_o = digits_i;
        cur_o    = cur_i;
        for (int i = 0; i < NSTAGE; i++) begin
            if ((cur_i != '0) && (i == int'(cur_i) - 1)) begin
                digits_o[i] = DG_ZERO;
                cur_o       = CW'(i);
            end
        end
    end

endmodule

// File: rtl/ordret_pattern.sv
// Splits the digit vector into the value and care vectors seen by the store.
module ordret_pattern
    import ordret_pkg::*;
#(
    parameter int NSTAGE = 6
) (
    input  digit_t [NSTAGE-1:0] digits_i,
    output logic   [NSTAGE-1:0] val_o,
    output logic   [NSTAGE-1:0] care_o
);

    for (genvar g = 0; g < NSTAGE; g++) begin : g_pos
        assign care_o[g] = digits_i[g][1];
        assign val_o[g]  = digits_i[g][0];
    end

endmodule

// File: rtl/ordret_ctrl.sv
module ordret_ctrl
    import ordret_pkg::*;
#(
    parameter int NSTAGE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        match_i,
    output logic              probe_o,
    output logic [NSTAGE-1:0] pat_val_o,
    output logic [NSTAGE-1:0] pat_care_o,
    output logic              retrieve_o,
    output logic              done_o
);

    localparam int CW = (NSTAGE > 1) ? $clog2(NSTAGE) : 1;
    localparam logic [CW-1:0] TOP = CW'(NSTAGE - 1);

    state_t                state_q, state_d;
    digit_t [NSTAGE-1:0]   digits_q, digits_d;
    logic   [CW-1:0]       cur_q, cur_d;

    digit_t [NSTAGE-1:0]   carry_digits;
    logic   [CW-1:0]       carry_cur;
    logic                  carry_out;
    digit_t [NSTAGE-1:0]   dive_digits;
    logic   [CW-1:0]       dive_cur;
    resp_t                 resp;

    ordret_carry #(.NSTAGE(NSTAGE), .CW(CW)) carry_i (
        .digits_i    (digits_q),
        .cur_i       (cur_q),
        .digits_o    (carry_digits),
        .cur_o       (carry_cur),
        .exhausted_o (carry_out)
    );

    ordret_descend #(.NSTAGE(NSTAGE), .CW(CW)) descend_i (
        .digits_i (digits_q),
        .cur_i    (cur_q),
        .digits_o (dive_digits),
        .cur_o    (dive_cur)
    );

    ordret_pattern #(.NSTAGE(NSTAGE)) pattern_i (
        .digits_i (digits_q),
        .val_o    (pat_val_o),
        .care_o   (pat_care_o)
    );

    assign resp = decode_resp(match_i);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            for (int i = 0; i < NSTAGE; i++) begin
                digits_q[i] <= DG_FREE;
            end
        end else begin
            state_q  <= state_d;
            cur_q    <= cur_d;
            digits_q <= digits_d;
        end
    end

    // Next state and digit update
    always_comb begin
        state_d  = state_q;
        digits_d = digits_q;
        cur_d    = cur_q;
        unique case (state_q)
            ST_IDLE, ST_FIN: begin
                if (start_i) begin
                    for (int i = 0; i < NSTAGE; i++) begin
                        digits_d[i] = DG_FREE;
                    end
                    digits_d[NSTAGE-1] = DG_ZERO;
                    cur_d              = TOP;
                    state_d            = ST_ASK;
                end
            end
            ST_ASK: begin
                unique case (resp)
                    RSP_NONE: state_d = ST_STEP;
                    RSP_ONE:  state_d = ST_TAKE;
                    RSP_MANY: state_d = (cur_q == '0) ? ST_TAKE : ST_DIVE;
                    default:  state_d = ST_STEP;
                endcase
            end
            ST_TAKE: begin
                state_d = ST_STEP;
            end
            ST_DIVE: begin
                digits_d = dive_digits;
                cur_d    = dive_cur;
                state_d  = ST_ASK;
            end
            ST_STEP: begin
                digits_d = carry_digits;
                cur_d    = carry_cur;
                state_d  = carry_out ? ST_FIN : ST_ASK;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        probe_o    = 1'b0;
        retrieve_o = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_ASK:  probe_o    = 1'b1;
            ST_TAKE: retrieve_o = 1'b1;
            ST_FIN:  done_o     = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ordret_ctrl_chk.sv
module ordret_ctrl_chk #(
    parameter int NSTAGE = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [1:0]        match_i,
    input logic              probe_o,
    input logic [NSTAGE-1:0] pat_val_o,
    input logic [NSTAGE-1:0] pat_care_o,
    input logic              retrieve_o,
    input logic              done_o
);

    logic [NSTAGE-1:0] free_v;
    logic [NSTAGE-1:0] free_inc;
    assign free_v   = ~pat_care_o;
    assign free_inc = free_v + 1'b1;

    // R5: a retrieval directly follows a probe and keeps its pattern
    a_r5_take_after_probe: assert property (@(posedge clk) disable iff (!rst_n)
        retrieve_o |-> ($past(probe_o) && $stable(pat_val_o) && $stable(pat_care_o)));

    // R8: a plural answer that leads to retrieval only happens at full depth
    a_r8_dup_full_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (retrieve_o && $past(match_i[1])) |-> (&pat_care_o));

    // R9: once finished, no position is specified
    a_r9_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pat_care_o == '0));

    // R9: done is held until a new start
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R2: every probe specifies the most significant position
    a_r2_top_specified: assert property (@(posedge clk) disable iff (!rst_n)
        probe_o |-> pat_care_o[NSTAGE-1]);

    // R6: specified positions always form one run from the top down
    a_r6_care_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        probe_o |-> ((free_v & free_inc) == '0));

    // R5: probe and retrieve never coincide
    a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({probe_o, retrieve_o, done_o}));

endmodule

bind ordret_ctrl ordret_ctrl_chk #(.NSTAGE(NSTAGE)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .match_i    (match_i),
    .probe_o    (probe_o),
    .pat_val_o  (pat_val_o),
    .pat_care_o (pat_care_o),
    .retrieve_o (retrieve_o),
    .done_o     (done_o)
);

// File: tb/ordret_ctrl_tb_top.sv
module ordret_ctrl_tb_top;

    localparam int N          = 6;
    localparam int MAXW       = 16;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   match;
    logic         probe, retrieve, done;
    logic [N-1:0] pval, pcare;

    logic [N-1:0] mem [MAXW];
    int           nwords = 0;
    logic [1:0]   plural_code = 2'b10;

    logic [N-1:0] got [MAXW];
    int           ngot;
    int           nstrobe;
    logic [N-1:0] lv [256];
    logic [N-1:0] lc [256];
    int           nprobe;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ordret_ctrl #(.NSTAGE(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .match_i    (match),
        .probe_o    (probe),
        .pat_val_o  (pval),
        .pat_care_o (pcare),
        .retrieve_o (retrieve),
        .done_o     (done)
    );

    // Store model: parallel ternary comparison
    always_comb begin
        int cnt;
        cnt = 0;
        for (int k = 0; k < nwords; k++) begin
            if (((mem[k] ^ pval) & pcare) == '0) cnt++;
        end
        match = (cnt == 0) ? 2'b00 : (cnt == 1) ? 2'b01 : plural_code;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int count_prefix(input int d, input int p);
        int c;
        c = 0;
        for (int k = 0; k < nwords; k++) begin
            if (int'(mem[k] >> (N - d)) == p) c++;
        end
        return c;
    endfunction

    // R10: probe count from the prefix rule
    function automatic int exp_probes();
        int t;
        t = 2;
        for (int d = 1; d < N; d++) begin
            for (int p = 0; p < (1 << d); p++) begin
                if (count_prefix(d, p) >= 2) t += 2;
            end
        end
        return t;
    endfunction

    task automatic run_search(input bit busy_start);
        int cyc;
        ngot = 0; nstrobe = 0; nprobe = 0; cyc = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (cyc < 3000) begin
            if (busy_start && nprobe == 3 && probe) start = 1'b1;
            else start = 1'b0;
            if (probe) begin
                lv[nprobe] = pval; lc[nprobe] = pcare;
                nprobe++;
            end
            if (retrieve) begin
                int cnt;
                cnt = 0;
                nstrobe++;
                for (int k = 0; k < nwords; k++) begin
                    if (((mem[k] ^ pval) & pcare) == '0) begin
                        cnt++;
                        if (ngot < MAXW) got[ngot] = mem[k];
                        ngot++;
                    end
                end
                chk(cnt >= 1, "R5", "words under retrieve", cnt, 1);
                if (cnt > 1) chk(pcare == '1, "R8", "care at duplicate take",
                                 int'(pcare), (1 << N) - 1);
            end
            if (done) break;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done, "R9", "done reached", int'(done), 1);
        chk(pcare == '0, "R9", "care at done", int'(pcare), 0);
        chk(lv[0] == '0 && lc[0] == N'(1 << (N-1)), "R2", "first probe care",
            int'(lc[0]), 1 << (N-1));
    endtask

    task automatic check_order();
        logic [N-1:0] srt [MAXW];
        bit ok;
        for (int k = 0; k < nwords; k++) srt[k] = mem[k];
        for (int a = 1; a < nwords; a++) begin
            for (int b = a; b > 0; b--) begin
                if (srt[b] < srt[b-1]) begin
                    logic [N-1:0] t;
                    t = srt[b]; srt[b] = srt[b-1]; srt[b-1] = t;
                end
            end
        end
        chk(ngot == nwords, "R10", "words retrieved", ngot, nwords);
        ok = (ngot == nwords);
        for (int k = 0; k < nwords && k < ngot; k++) begin
            if (got[k] != srt[k]) begin
                ok = 0;
                $display("FAIL R10 order slot %0d: actual %0d expected %0d",
                         k, got[k], srt[k]);
            end
        end
        chk(ok, "R10", "ascending order", ngot, nwords);
        chk(nprobe == exp_probes(), "R10", "probe count", nprobe, exp_probes());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0005_1eed));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!probe && !retrieve && !done && pcare == '0, "R1", "reset outputs",
            int'({probe, retrieve, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: empty store -> 0 then 1 at top, then done
        nwords = 0;
        run_search(0);
        chk(nprobe == 2, "R4", "probes on empty store", nprobe, 2);
        chk(lv[1] == N'(1 << (N-1)) && lc[1] == N'(1 << (N-1)), "R4",
            "second probe value", int'(lv[1]), 1 << (N-1));
        repeat (3) @(negedge clk);
        chk(done && !probe, "R9", "done held", int'(done), 1);

        // R6, R7, R11: words 0 and 1, with a start pulse mid-search
        nwords = 2; mem[0] = 6'd1; mem[1] = 6'd0;
        run_search(1);
        chk(lv[1] == '0 && lc[1] == 6'b110000, "R6", "descend care",
            int'(lc[1]), 6'b110000);
        chk(lv[7] == 6'b000010 && lc[7] == 6'b111110, "R7", "carry pattern value",
            int'(lv[7]), 6'b000010);
        chk(lc[7] == 6'b111110, "R7", "carry pattern care", int'(lc[7]), 6'b111110);
        chk(nprobe == 12, "R11", "probes with busy start", nprobe, 12);
        check_order();

        // R8, R3: triple duplicate with plural code 2'b11
        plural_code = 2'b11;
        nwords = 3; mem[0] = 6'd7; mem[1] = 6'd7; mem[2] = 6'd7;
        run_search(0);
        chk(nstrobe == 1, "R8", "one strobe for duplicates", nstrobe, 1);
        chk(ngot == 3, "R3", "plural 2'b11 honoured", ngot, 3);
        check_order();

        // R5: seven distinct words
        plural_code = 2'b10;
        nwords = 7;
        mem[0] = 6'd44; mem[1] = 6'd3; mem[2] = 6'd60; mem[3] = 6'd17;
        mem[4] = 6'd18; mem[5] = 6'd33; mem[6] = 6'd9;
        run_search(0);
        chk(nstrobe == 7, "R5", "one strobe per distinct word", nstrobe, 7);
        check_order();

        // Random fills
        for (int r = 0; r < 30; r++) begin
            int lim;
            nwords = $urandom_range(0, 12);
            lim = ($urandom_range(0, 1) == 1) ? 7 : 63;
            plural_code = ($urandom_range(0, 1) == 1) ? 2'b11 : 2'b10;
            for (int k = 0; k < nwords; k++) mem[k] = N'($urandom_range(0, lim));
            run_search(0);
            check_order();
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule